// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns the 16-bit sum and the carry-out. The datapath is split into four 4-bit groups. Each group builds per-bit generate (`a AND b`) and propagate (`a OR b`) terms. From those terms it computes every internal carry as a flat sum of products, so no carry inside a group waits for another carry.

Each group also reduces its bit terms to a single group generate and a single group propagate. A second lookahead stage of the same form takes these four pairs and the global carry-in, and produces the carry into every group and the final carry-out in one flat step. Carries therefore never ripple from one group to the next. The group width and the group count are parameters. One generic lookahead unit serves both levels.

A typical use is as the adder core of an integer ALU. Subtraction is obtained there by inverting one operand and forcing the carry-in high.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, taking both operands as unsigned values.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned result `op_a + op_b + carry_in`.
- R3: When every bit position has exactly one operand bit set (`op_a ^ op_b` all ones), `carry_in` passes through all groups. With `carry_in` = 1 the outputs are sum 0x0000 and carry_out 1. With `carry_in` = 0 they are sum 0xFFFF and carry_out 0.
- R4: A group whose bits generate a carry on their own drives a 1 into the next group whatever the carry into it is. For example, 0x00F0 + 0x0010 gives 0x0100, with carry_in 0 or 1 (1 adds one to the sum).
- R5: The carry into group k+1 from the second-level lookahead equals the carry that group k derives internally from its own bits and its carry-in. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.
- R6: Each 4-bit group adds correctly for all 512 combinations of its operand nibbles and its carry-in, whichever group position it sits at. Bits 0-3, 4-7, 8-11 and 12-15 form the groups.
- R7: With both operands zero the outputs are sum = carry_in and carry_out 0.
- R8: 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF and carry_out 1. 0xFFFF + 0xFFFF + 0 gives sum 0xFFFE and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The immediate assertions inside the adder assume that `op_a`, `op_b` and `carry_in` are settled, two-state values when the combinational logic is evaluated. An X or a mid-update value would make the flat carry relations look broken. The bench therefore changes all inputs together with nonblocking assignments on one clock edge and drives only 0/1 values, so every check sees fully settled inputs. The stimulus covers every nibble combination at every group position, all-propagate and all-generate patterns, and random operands. This reaches both the pass-through and the kill cases of the group and block lookahead relations.

// File: rtl/la_pkg.sv
package la_pkg;

  localparam int LA_GROUP_W_DEF = 4;
  localparam int LA_GROUPS_DEF  = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } la_gp_t;

  function automatic logic la_sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic la_bit_gen(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic la_bit_prop(input logic a, input logic b);
    return a | b;
  endfunction

endpackage

// File: rtl/la_lookahead.sv
module la_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         blk_gen,
  output logic         blk_prop
);

  // Every carry is a flat OR of products: c[i+1] = OR_j (g[j] & p[j+1..i]) | (c0 & p[0..i])
  function automatic logic [N:0] carry_vec(input logic [N-1:0] g, input logic [N-1:0] p,
                                           input logic c0);
    logic [N:0] c;
    logic       prod;
    c    = '0;
    c[0] = c0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j <= i; j++) begin
        prod = g[j];
        for (int k = j + 1; k <= i; k++) prod = prod & p[k];
        c[i+1] = c[i+1] | prod;
      end
      prod = c0;
      for (int k = 0; k <= i; k++) prod = prod & p[k];
      c[i+1] = c[i+1] | prod;
    end
    return c;
  endfunction

  function automatic logic blk_generate(input logic [N-1:0] g, input logic [N-1:0] p);
    logic r;
    logic prod;
    r = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = g[j];
      for (int k = j + 1; k < N; k++) prod = prod & p[k];
      r = r | prod;
    end
    return r;
  endfunction

  function automatic logic blk_propagate(input logic [N-1:0] p);
    return &p;
  endfunction

  assign carry    = carry_vec(gen_i, prop_i, cin);
  assign blk_gen  = blk_generate(gen_i, prop_i);
  assign blk_prop = blk_propagate(prop_i);

  always_comb begin
    // R4: a generating block always carries out
    a_r4_gen_forces_carry: assert (!blk_gen || carry[N])
      else $error("block generate without carry out");
    // R3: a propagating, non-generating block passes its carry-in through
    a_r3_prop_passes_cin: assert (!(blk_prop && !blk_gen) || (carry[N] == cin))
      else $error("propagate path does not pass carry-in");
    // R2: a block that neither generates nor propagates kills the carry
    a_r2_kill_clears_carry: assert (blk_prop || blk_gen || !carry[N])
      else $error("killed block still carries out");
  end

endmodule

// File: rtl/la_group.sv
module la_group
  import la_pkg::*;
#(
  parameter int W = la_pkg::LA_GROUP_W_DEF
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output la_gp_t       gp,
  output logic         cout
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W:0]   c_int;
  logic         g_blk;
  logic         p_blk;

  for (genvar i = 0; i < W; i++) begin : g_bits
    assign bit_g[i] = la_bit_gen(a[i], b[i]);
    assign bit_p[i] = la_bit_prop(a[i], b[i]);
    assign sum[i]   = la_sum_bit(a[i], b[i], c_int[i]);
  end

  la_lookahead #(.N(W)) u_la (
    .gen_i   (bit_g),
    .prop_i  (bit_p),
    .cin     (cin),
    .carry   (c_int),
    .blk_gen (g_blk),
    .blk_prop(p_blk)
  );

  assign gp.gen  = g_blk;
  assign gp.prop = p_blk;
  assign cout    = c_int[W];

  always_comb begin
    // R6: the group result matches a plain addition of its nibbles
    a_r6_group_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("group sum mismatch");
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import la_pkg::*;
#(
  parameter int GROUP_W = la_pkg::LA_GROUP_W_DEF,
  parameter int GROUPS  = la_pkg::LA_GROUPS_DEF,
  localparam int WIDTH  = GROUP_W * GROUPS
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  la_gp_t [GROUPS-1:0] grp_gp;
  logic [GROUPS-1:0]   grp_g;
  logic [GROUPS-1:0]   grp_p;
  logic [GROUPS-1:0]   grp_cout;
  logic [GROUPS:0]     tree_c;
  logic                tree_gen;
  logic                tree_prop;

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    la_group #(.W(GROUP_W)) u_grp (
      .a   (op_a[gi*GROUP_W +: GROUP_W]),
      .b   (op_b[gi*GROUP_W +: GROUP_W]),
      .cin (tree_c[gi]),
      .sum (sum_out[gi*GROUP_W +: GROUP_W]),
      .gp  (grp_gp[gi]),
      .cout(grp_cout[gi])
    );
    assign grp_g[gi] = grp_gp[gi].gen;
    assign grp_p[gi] = grp_gp[gi].prop;

    always_comb begin
      // R5: second-level carry agrees with the group's own internal carry-out
      a_r5_boundary_carry: assert (grp_cout[gi] == tree_c[gi+1])
        else $error("group boundary carry mismatch");
    end
  end

  la_lookahead #(.N(GROUPS)) u_tree (
    .gen_i   (grp_g),
    .prop_i  (grp_p),
    .cin     (carry_in),
    .carry   (tree_c),
    .blk_gen (tree_gen),
    .blk_prop(tree_prop)
  );

  assign carry_out = tree_c[GROUPS];

  always_comb begin
    // R1: full-width sum
    a_r1_sum: assert (sum_out == WIDTH'({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("sum mismatch");
    // R2: carry-out is bit WIDTH of the full result
    a_r2_carry_out: assert (carry_out == ((WIDTH+1)'({1'b0, op_a} + {1'b0, op_b}
                                           + {{WIDTH{1'b0}}, carry_in}) >> WIDTH))
      else $error("carry-out mismatch");
    // R3: all groups propagating and none generating passes carry_in to the output
    a_r3_full_propagate: assert (!(tree_prop && !tree_gen) || (carry_out == carry_in))
      else $error("full propagate path broken");
    // R4: whole-word generate forces carry_out
    a_r4_word_generate: assert (!tree_gen || carry_out)
      else $error("word generate without carry out");
  end

endmodule

// File: tb/lookahead_adder_test.sv
module lookahead_adder_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         ci = 1'b0;
  logic [W-1:0] s;
  logic         co;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W:0]   exp_q[$];
  logic [W-1:0] a_q[$];
  logic [W-1:0] b_q[$];
  logic         c_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  lookahead_adder uut (
    .op_a     (a),
    .op_b     (b),
    .carry_in (ci),
    .sum_out  (s),
    .carry_out(co)
  );

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic c);
    int unsigned t;
    t = int'(x) + int'(y) + (c ? 1 : 0);
    return t[W:0];
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                       input string tag);
    @(posedge clk);
    a  <= x;
    b  <= y;
    ci <= c;
    exp_q.push_back(model(x, y, c));
    a_q.push_back(x);
    b_q.push_back(y);
    c_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                           input logic [W:0] e, input string tag);
    @(posedge clk);
    a  <= x;
    b  <= y;
    ci <= c;
    exp_q.push_back(e);
    a_q.push_back(x);
    b_q.push_back(y);
    c_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected item per cycle, mid-period
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [W:0]   e;
      logic [W-1:0] xa, xb;
      logic         xc;
      string        t;
      e  = exp_q.pop_front();
      xa = a_q.pop_front();
      xb = b_q.pop_front();
      xc = c_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if ({co, s} !== e) begin
        errors++;
        $display("FAIL %s a=%h b=%h cin=%0d actual co=%0d sum=%h expected co=%0d sum=%h",
                 t, xa, xb, xc, co, s, e[W], e[W-1:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // R7: idle state after reset
    drive_exp(16'h0000, 16'h0000, 1'b0, 17'h00000, "R7");
    drive_exp(16'h0000, 16'h0000, 1'b1, 17'h00001, "R7");
    // R3: full propagate
    drive_exp(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R3");
    drive_exp(16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF, "R3");
    drive_exp(16'hA5A5, 16'h5A5A, 1'b1, 17'h10000, "R3");
    drive_exp(16'h1234, 16'hEDCB, 1'b0, 17'h0FFFF, "R3");
    // R4: group generate into next group
    drive_exp(16'h00F0, 16'h0010, 1'b0, 17'h00100, "R4");
    drive_exp(16'h00F0, 16'h0010, 1'b1, 17'h00101, "R4");
    drive_exp(16'h8000, 16'h8000, 1'b0, 17'h10000, "R4");
    // R5: carries crossing group boundaries
    drive_exp(16'h000F, 16'h0001, 1'b0, 17'h00010, "R5");
    drive_exp(16'h0FFF, 16'h0001, 1'b0, 17'h01000, "R5");
    drive_exp(16'h00FF, 16'h0000, 1'b1, 17'h00100, "R5");
    // R8: extremes
    drive_exp(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R8");
    drive_exp(16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE, "R8");
    // R6: exhaustive nibble sweep at every group position
    for (int g = 0; g < 4; g++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++)
            drive(W'(x) << (4*g), W'(y) << (4*g), (g == 0) ? c[0] : 1'b0, "R6");
    // R6: carry_in into upper groups via all-propagate low bits
    for (int g = 1; g < 4; g++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          logic [W-1:0] lo;
          lo = W'((1 << (4*g)) - 1);
          drive((W'(x) << (4*g)) | lo, W'(y) << (4*g), 1'b1, "R6");
        end
    // R1/R2: random operands
    for (int i = 0; i < 400; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), (i % 2 == 0) ? "R1" : "R2");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule